// File: doc/BRIEF.md
# Guest Log Line Buffer

This block takes the bytes that guest software writes into a debug log register and gathers them into a line buffer. When a line is complete, the block sends it out as a byte stream. Two separate register decodes can carry a log byte. One is a byte write to offset 2 of a small fixed port block. The other is a byte write to offset 8 of a PCI I/O window. Both feed one write path inside the block.

A line is complete when a newline (0x0A) arrives or when the buffer can hold no more. The newline itself is never kept. A byte that arrives when the buffer is already full is thrown away. The finished line goes out on a valid/ready stream: first the stored bytes in order, then a zero terminator, with `line_last` high only on the terminator. While a line is being sent, both write paths show not-ready. The host keeps its write asserted until it is accepted, so no byte is lost and none is reordered.

The controller has three states:
- `ST_FILL` collects bytes. On a closing write it moves to `ST_SEND` if bytes are stored, or straight to `ST_TERM` if the line is empty.
- `ST_SEND` streams the stored bytes. It moves to `ST_TERM` when the final stored byte is accepted.
- `ST_TERM` presents the terminator. It returns to `ST_FILL` when the terminator is accepted.

Synchronous reset returns the controller to `ST_FILL` from any state.

Top module: `glog_line_buf`

## Requirements
- R1: A byte is accepted only when one of two conditions holds: `fix_wr` is high with `fix_addr` == 2 and `fix_ready` is high, or `pci_wr` is high with `pci_addr` == 8 and `pci_ready` is high. Writes to any other offset have no effect on the stream.
- R2: When both decodes hit in the same cycle, the fixed-port byte is taken first and `pci_ready` is low in that cycle. The PCI byte is taken in a later cycle.
- R3: An accepted byte that is not 0x0A, written while the fill count is below DEPTH-1, is stored at the fill position and the fill count grows by one.
- R4: An accepted 0x0A closes the line and is not stored.
- R5: An accepted byte written while the fill count equals DEPTH-1 closes the line and is dropped. A line therefore carries at most DEPTH-1 data bytes.
- R6: A closed line is streamed as its stored bytes in arrival order, then one 0x00 byte. `line_last` is high only on that 0x00 byte. Afterwards the fill count is zero.
- R7: A line closed with a fill count of zero emits only the terminator.
- R8: While `line_valid` is high, `fix_ready` and `pci_ready` are both low and no byte is accepted.
- R9: While `line_valid` is high and `line_ready` is low, `line_valid`, `line_data` and `line_last` hold their values.
- R10: Synchronous reset `rst` clears the fill count and ends any stream in progress, so that `line_valid` is low in the cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fix_wr | input | 1 | Byte write strobe, fixed port block |
| fix_addr | input | FIX_AW | Byte offset in the fixed port block |
| fix_wdata | input | 8 | Write data, fixed port block |
| fix_ready | output | 1 | Fixed-port log write may be taken |
| pci_wr | input | 1 | Byte write strobe, PCI I/O window |
| pci_addr | input | PCI_AW | Byte offset in the PCI I/O window |
| pci_wdata | input | 8 | Write data, PCI I/O window |
| pci_ready | output | 1 | PCI-window log write may be taken |
| line_valid | output | 1 | Output byte valid |
| line_data | output | 8 | Output byte |
| line_last | output | 1 | Output byte is the terminator |
| line_ready | input | 1 | Consumer accepts the output byte |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the two write decodes. The bench drives both strobes together at their log offsets, once with ordinary bytes and once with a newline on the fixed port. It then judges that the fixed byte lands first, that the held PCI byte lands next or opens the following line, and that `pci_ready` was low in the shared cycle. The second pair is a line close and a buffer-full condition. A run of DEPTH+1 bytes with no newline makes the closing write coincide with the full count, and the bench checks that this byte is absent from the stream. A reference model built from queues is compared with the readies and the stream on every clock, including cycles where the output is stalled and where reset lands in the middle of a stream.

// File: rtl/glog_pkg.sv
package glog_pkg;
    typedef enum logic [1:0] {
        ST_FILL = 2'd0,
        ST_SEND = 2'd1,
        ST_TERM = 2'd2
    } glog_state_t;

    localparam logic [7:0] GLOG_NEWLINE = 8'h0A;
    localparam logic [7:0] GLOG_TERM    = 8'h00;
endpackage

// File: rtl/glog_wr_merge.sv
module glog_wr_merge #(
    parameter int FIX_AW  = 4,
    parameter int PCI_AW  = 8,
    parameter int FIX_OFF = 2,
    parameter int PCI_OFF = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              open_i,
    input  logic              fix_wr,
    input  logic [FIX_AW-1:0] fix_addr,
    input  logic [7:0]        fix_wdata,
    input  logic              pci_wr,
    input  logic [PCI_AW-1:0] pci_addr,
    input  logic [7:0]        pci_wdata,
    output logic              fix_ready,
    output logic              pci_ready,
    output logic              acc_o,
    output logic [7:0]        byte_o
);
    logic fix_hit;
    logic pci_hit;

    always_comb begin
        fix_hit   = fix_wr && (fix_addr == FIX_AW'(FIX_OFF));
        pci_hit   = pci_wr && (pci_addr == PCI_AW'(PCI_OFF));
        fix_ready = open_i;
        pci_ready = open_i && !fix_hit;
        acc_o     = open_i && (fix_hit || pci_hit);
        byte_o    = fix_hit ? fix_wdata : pci_wdata;
    end

    AST_ONE_WINNER: assert property (@(posedge clk) disable iff (rst)
        (fix_hit && fix_ready) |-> !pci_ready) else $error("pci taken with fixed"); // R2
endmodule

// File: rtl/glog_line_store.sv
module glog_line_store #(
    parameter int DEPTH = 4096,
    localparam int CW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_i,
    input  logic [7:0]    wdata_i,
    input  logic          clear_i,
    input  logic [CW-1:0] raddr_i,
    output logic [7:0]    rdata_o,
    output logic [CW-1:0] cnt_o
);
    logic [7:0]    mem [DEPTH];
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (push_i) begin
            mem[cnt] <= wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            cnt <= '0;
        end else if (push_i) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign rdata_o = mem[raddr_i];
    assign cnt_o   = cnt;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        push_i |-> (cnt != CW'(DEPTH - 1))) else $error("store past full"); // R5
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (cnt == '0)) else $error("count not cleared"); // R6
endmodule

// File: rtl/glog_line_buf.sv
module glog_line_buf
    import glog_pkg::*;
#(
    parameter int DEPTH   = 4096,
    parameter int FIX_AW  = 4,
    parameter int PCI_AW  = 8,
    parameter int FIX_OFF = 2,
    parameter int PCI_OFF = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fix_wr,
    input  logic [FIX_AW-1:0] fix_addr,
    input  logic [7:0]        fix_wdata,
    output logic              fix_ready,
    input  logic              pci_wr,
    input  logic [PCI_AW-1:0] pci_addr,
    input  logic [7:0]        pci_wdata,
    output logic              pci_ready,
    output logic              line_valid,
    output logic [7:0]        line_data,
    output logic              line_last,
    input  logic              line_ready
);
    localparam int CW = $clog2(DEPTH);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH - 1);

    glog_state_t   state, state_nx;
    logic [CW-1:0] rd_idx;
    logic [CW-1:0] cnt;
    logic [7:0]    rdata;
    logic          acc;
    logic [7:0]    wbyte;
    logic          closing;
    logic          push;
    logic          clear;

    glog_wr_merge #(
        .FIX_AW (FIX_AW),
        .PCI_AW (PCI_AW),
        .FIX_OFF(FIX_OFF),
        .PCI_OFF(PCI_OFF)
    ) u_merge (
        .clk      (clk),
        .rst      (rst),
        .open_i   (state == ST_FILL),
        .fix_wr   (fix_wr),
        .fix_addr (fix_addr),
        .fix_wdata(fix_wdata),
        .pci_wr   (pci_wr),
        .pci_addr (pci_addr),
        .pci_wdata(pci_wdata),
        .fix_ready(fix_ready),
        .pci_ready(pci_ready),
        .acc_o    (acc),
        .byte_o   (wbyte)
    );

    glog_line_store #(
        .DEPTH(DEPTH)
    ) u_store (
        .clk    (clk),
        .rst    (rst),
        .push_i (push),
        .wdata_i(wbyte),
        .clear_i(clear),
        .raddr_i(rd_idx),
        .rdata_o(rdata),
        .cnt_o  (cnt)
    );

    assign closing = acc && ((wbyte == GLOG_NEWLINE) || (cnt == FULL_CNT));
    assign push    = acc && !closing;
    assign clear   = (state == ST_TERM) && line_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_FILL;
            rd_idx <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_FILL) begin
                rd_idx <= '0;
            end else if ((state == ST_SEND) && line_ready) begin
                rd_idx <= rd_idx + 1'b1;
            end
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FILL: if (closing) state_nx = (cnt == '0) ? ST_TERM : ST_SEND;
            ST_SEND: if (line_ready && (rd_idx == cnt - 1'b1)) state_nx = ST_TERM;
            ST_TERM: if (line_ready) state_nx = ST_FILL;
            default: state_nx = ST_FILL;
        endcase
    end

    always_comb begin
        line_valid = 1'b0;
        line_data  = GLOG_TERM;
        line_last  = 1'b0;
        unique case (state)
            ST_FILL: ;
            ST_SEND: begin
                line_valid = 1'b1;
                line_data  = rdata;
            end
            ST_TERM: begin
                line_valid = 1'b1;
                line_last  = 1'b1;
            end
            default: ;
        endcase
    end

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (line_valid && !line_ready) |=> (line_valid && $stable(line_data) && $stable(line_last)))
        else $error("stream changed under stall"); // R9
    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        line_valid |-> (!fix_ready && !pci_ready)) else $error("write open while sending"); // R8
    AST_LAST_ZERO: assert property (@(posedge clk) disable iff (rst)
        (line_valid && line_last) |-> (line_data == GLOG_TERM)) else $error("terminator not zero"); // R6
    AST_EMPTY_TERM: assert property (@(posedge clk) disable iff (rst)
        (closing && cnt == '0) |=> (line_valid && line_last)) else $error("empty line not terminator"); // R7
    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> !line_valid) else $error("stream alive after reset"); // R10
endmodule

// File: tb/glog_line_buf_test.sv
`timescale 1ns/1ps
module glog_line_buf_test;
    localparam int DEPTH = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fix_wr = 1'b0;
    logic [3:0] fix_addr = '0;
    logic [7:0] fix_wdata = '0;
    logic       pci_wr = 1'b0;
    logic [7:0] pci_addr = '0;
    logic [7:0] pci_wdata = '0;
    logic       line_ready = 1'b1;
    logic       fix_ready, pci_ready, line_valid, line_last;
    logic [7:0] line_data;

    glog_line_buf #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst),
        .fix_wr(fix_wr), .fix_addr(fix_addr), .fix_wdata(fix_wdata), .fix_ready(fix_ready),
        .pci_wr(pci_wr), .pci_addr(pci_addr), .pci_wdata(pci_wdata), .pci_ready(pci_ready),
        .line_valid(line_valid), .line_data(line_data), .line_last(line_last),
        .line_ready(line_ready)
    );

    always #10 clk = ~clk;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc = 0;
    bit    stall_mode = 1'b0;
    string tag = "R10";

    logic [7:0] cur_q[$];
    logic [7:0] out_q[$];
    logic       m_idle, m_fh, m_ph;
    logic [7:0] m_b;

    // Reference model, advanced on every clock
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            cur_q.delete();
            out_q.delete();
        end else begin
            m_idle = (out_q.size() == 0);
            m_fh   = fix_wr && (fix_addr == 4'd2);
            m_ph   = pci_wr && (pci_addr == 8'd8);
            if (!m_idle && line_ready) begin
                void'(out_q.pop_front());
            end else if (m_idle && (m_fh || m_ph)) begin
                m_b = m_fh ? fix_wdata : pci_wdata;
                if (m_b == 8'h0A || cur_q.size() == DEPTH - 1) begin
                    out_q = cur_q;
                    out_q.push_back(8'h00);
                    cur_q.delete();
                end else begin
                    cur_q.push_back(m_b);
                end
            end
        end
    end

    task automatic check(input string what, input logic [7:0] got, input logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // Comparison on every clock, away from the edges
    always @(negedge clk) begin
        #2;
        check("line_valid", {7'd0, line_valid}, {7'd0, out_q.size() != 0});
        check("fix_ready", {7'd0, fix_ready}, {7'd0, out_q.size() == 0});
        check("pci_ready", {7'd0, pci_ready},
              {7'd0, (out_q.size() == 0) && !(fix_wr && fix_addr == 4'd2)});
        if (out_q.size() != 0) begin
            check("line_data", line_data, out_q[0]);
            check("line_last", {7'd0, line_last}, {7'd0, out_q.size() == 1});
        end
    end

    always @(negedge clk) begin
        line_ready = stall_mode ? (cyc[0] ^ cyc[2]) : 1'b1;
    end

    always @(posedge clk) begin
        if (cyc == 60000) begin
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic wfix(input logic [7:0] b);
        fix_wr = 1'b1; fix_addr = 4'd2; fix_wdata = b;
        #1;
        while (!fix_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        fix_wr = 1'b0;
    endtask

    task automatic wpci(input logic [7:0] b);
        pci_wr = 1'b1; pci_addr = 8'd8; pci_wdata = b;
        #1;
        while (!pci_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        pci_wr = 1'b0;
    endtask

    task automatic wboth(input logic [7:0] fb, input logic [7:0] pb);
        fix_wr = 1'b1; fix_addr = 4'd2; fix_wdata = fb;
        pci_wr = 1'b1; pci_addr = 8'd8; pci_wdata = pb;
        #1;
        while (!fix_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        fix_wr = 1'b0;
        #1;
        while (!pci_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        pci_wr = 1'b0;
    endtask

    task automatic wstray(input logic [7:0] b);
        fix_wr = 1'b1; fix_addr = 4'd3; fix_wdata = b;
        pci_wr = 1'b1; pci_addr = 8'd9; pci_wdata = b;
        @(negedge clk);
        fix_addr = 4'd0; pci_addr = 8'd2;
        @(negedge clk);
        fix_wr = 1'b0; pci_wr = 1'b0;
    endtask

    task automatic wait_idle();
        #1;
        while (!fix_ready) begin @(negedge clk); #1; end
        @(negedge clk);
    endtask

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R3 R4: plain line closed by newline
        tag = "R4";
        wfix("A"); wfix("B"); wfix(8'h0A);
        wait_idle();
        // R1: PCI window bytes, stray offsets ignored
        tag = "R1";
        wpci("x"); wstray("?"); wpci("y"); wstray(8'h0A); wpci(8'h0A);
        wait_idle();
        // R7: empty line
        tag = "R7";
        wfix(8'h0A);
        wait_idle();
        // R5: fill past depth, closing byte dropped
        tag = "R5";
        for (int i = 0; i < DEPTH + 1; i++) wfix(8'h61 + 8'(i));
        wait_idle();
        wfix(8'h0A);
        wait_idle();
        // R2: both decodes at once
        tag = "R2";
        wboth("Q", "R"); wfix(8'h0A);
        wait_idle();
        wboth(8'h0A, "S"); wpci(8'h0A);
        wait_idle();
        // R9 R8 R6: stalled output, writes held off meanwhile
        tag = "R9";
        stall_mode = 1'b1;
        wfix("m"); wpci("n"); wfix("o"); wfix(8'h0A);
        wpci("p"); wfix(8'h0A);
        wait_idle();
        // R10: reset in the middle of a stream
        tag = "R10";
        wfix("u"); wfix("v"); wfix("w"); wfix(8'h0A);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        stall_mode = 1'b0;
        // R3 R6: count restarts from zero after reset
        tag = "R6";
        wfix("z"); wfix(8'h0A);
        wait_idle();
        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule